// File: doc/BRIEF.md
# High-Speed Lane Timing Code Generator

This block turns a serial display link's high-speed bit rate (in Mbps), the low-power clock period (in picoseconds) and two requested prepare durations (in picoseconds) into the small integer codes that program a PHY's lane timing. It produces a data prepare code, a clock prepare code, data and clock zero counts, one trail count shared by the data and clock lanes, and a receiver settle code. It also flags prepare requests that are too long to program.

A caller presents the operands and pulses `start` while the block is idle or finished. The block captures the operands and steps through four divisions on one shared restoring divider. It then raises `done` and holds every result until the next accepted `start`. The low-power period is an input here; deriving it from a frequency is left to the caller.

The state machine has six states. `S_IDLE` is the state after reset. `S_PREP`, `S_DZERO`, `S_CZERO` and `S_TRAIL` each issue one division and wait for it. `S_HOLD` presents the results. The transitions are: start accepted (`S_IDLE`/`S_HOLD` to `S_PREP`), then prepare done (to `S_DZERO`), data zero done (to `S_CZERO`), clock zero done (to `S_TRAIL`), and trail done (to `S_HOLD`).

Top module: `lanetim_gen`

## Requirements
- R1: A `start` seen while `busy` is low is accepted: the cycle after, `busy` is 1 and `done` is 0. A `start` while `busy` is high is ignored, and the run finishes with the results of the operands first accepted. `busy` and `done` are never high together.
- R2: With data prepare time p and period T, the 2-bit data prepare code is 0 when p < T, and otherwise floor(2·(p−T)/T) saturated at 3. Code k therefore means (2+k)/2 periods.
- R3: `data_prep_err` is 1 exactly when 2·p > 5·T.
- R4: The 1-bit clock prepare code is 1 when the clock prepare time c exceeds T, and 0 otherwise. `clk_prep_err` is 1 exactly when 2·c > 3·T.
- R5: The data zero count is floor((144·rate − 47500)/10000). A numerator below zero counts as 0, the result is raised to at least 1, and it is saturated at 255.
- R6: The clock zero count is floor((34·rate − 2500)/1000), with the same negative-to-0 rule, the same minimum of 1 and the same saturation at 255.
- R7: The trail count is floor((103·rate + 10000)/10000), clamped to the range 1..15. The single `trail_cnt` output serves both the data and the clock lane.
- R8: The settle code follows the rate. It is 13 for a rate below 80, 12 below 90, 11 below 125, 10 below 150, 9 below 225, 8 below 500, and 7 otherwise.
- R9: After reset, `busy`, `done` and all code outputs are 0. While `done` is 1 and no `start` arrives, `done` and all code and error outputs hold, even when the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a computation (accepted when not busy) |
| rate_mbps | input | RATE_W (11) | High-speed bit rate in Mbps |
| lp_period_ps | input | TIME_W (20) | Low-power clock period in ps (nonzero) |
| data_prep_ps | input | TIME_W (20) | Requested data lane prepare time in ps |
| clk_prep_ps | input | TIME_W (20) | Requested clock lane prepare time in ps |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Results valid; held until the next accepted start |
| data_prep_err | output | 1 | Data prepare request longer than 2.5 periods |
| clk_prep_err | output | 1 | Clock prepare request longer than 1.5 periods |
| data_prep_code | output | 2 | Data prepare code in half-period steps |
| clk_prep_code | output | 1 | Clock prepare code |
| data_zero | output | 8 | Data lane zero count |
| clk_zero | output | 8 | Clock lane zero count |
| trail_cnt | output | 4 | Trail count shared by data and clock lanes |
| settle_code | output | 4 | Receiver settle code |

## Verification
Two situations are hard to reach from the ports. The first is a second `start` that lands in the middle of a division, with different operands. The bench waits a fixed number of cycles into a run, drives a full set of new operands with a one-cycle `start`, and expects the results of the first set. The second is the low end of the rate range, where the zero formulas go negative and the floor clamp must take over. Directed rates of 0, 1, 73 and 330 sit on both sides of those crossings. Prepare times are drawn around multiples of the period so that the quantisation steps and both error limits are met both exactly and one picosecond past.

// File: rtl/lanetim_pkg.sv
package lanetim_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREP,
        S_DZERO,
        S_CZERO,
        S_TRAIL,
        S_HOLD
    } lanetim_state_e;

    // Linear rate formulas: (MUL*rate + OFS) / DIV
    localparam int DZ_MUL = 144;
    localparam int DZ_SUB = 47500;
    localparam int DZ_DIV = 10000;
    localparam int CZ_MUL = 34;
    localparam int CZ_SUB = 2500;
    localparam int CZ_DIV = 1000;
    localparam int TR_MUL = 103;
    localparam int TR_ADD = 10000;
    localparam int TR_DIV = 10000;
    localparam int TR_MAX = 15;

    // Settle ladder: a rate below LIM[i] gives CODE[i]
    localparam int SETTLE_STEPS = 6;
    localparam int SETTLE_LIM  [SETTLE_STEPS] = '{80, 90, 125, 150, 225, 500};
    localparam int SETTLE_CODE [SETTLE_STEPS] = '{13, 12, 11, 10, 9, 8};
    localparam int SETTLE_TOP  = 7;

endpackage

// File: rtl/lanetim_divider.sv
module lanetim_divider #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    shifted;
    logic [W+1:0]  trial;

    assign shifted = {rem_q, quot[W-1]};
    assign trial   = {1'b0, shifted} - {2'b00, den_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
            quot  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !run_q) begin
                rem_q <= '0;
                den_q <= den;
                quot  <= num;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!trial[W+1]) begin
                    rem_q <= trial[W-1:0];
                    quot  <= {quot[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quot  <= {quot[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lanetim_settle.sv
module lanetim_settle
    import lanetim_pkg::*;
#(
    parameter int RATE_W = 11
) (
    input  logic [RATE_W-1:0] rate,
    output logic [3:0]        code
);
    logic [SETTLE_STEPS-1:0] below;

    for (genvar i = 0; i < SETTLE_STEPS; i++) begin : g_cmp
        assign below[i] = (32'(rate) < SETTLE_LIM[i]);
    end

    always_comb begin
        code = 4'(SETTLE_TOP);
        for (int i = SETTLE_STEPS - 1; i >= 0; i--) begin
            if (below[i]) code = 4'(SETTLE_CODE[i]);
        end
    end
endmodule

// File: rtl/lanetim_gen.sv
module lanetim_gen
    import lanetim_pkg::*;
#(
    parameter int RATE_W = 11,
    parameter int TIME_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] rate_mbps,
    input  logic [TIME_W-1:0] lp_period_ps,
    input  logic [TIME_W-1:0] data_prep_ps,
    input  logic [TIME_W-1:0] clk_prep_ps,
    output logic              busy,
    output logic              done,
    output logic              data_prep_err,
    output logic              clk_prep_err,
    output logic [1:0]        data_prep_code,
    output logic              clk_prep_code,
    output logic [7:0]        data_zero,
    output logic [7:0]        clk_zero,
    output logic [3:0]        trail_cnt,
    output logic [3:0]        settle_code
);
    localparam int RW    = (RATE_W + 8 > 16) ? RATE_W + 8 : 16;
    localparam int DIV_W = (TIME_W + 1 > RW) ? TIME_W + 1 : RW;
    localparam int EW    = TIME_W + 3;

    lanetim_state_e state, state_nx;

    logic [RATE_W-1:0] r_rate;
    logic [TIME_W-1:0] r_per;
    logic [TIME_W-1:0] r_prep;
    logic              launched;
    logic              accept;
    logic              div_start;
    logic              div_done;
    logic [DIV_W-1:0]  div_num;
    logic [DIV_W-1:0]  div_den;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  prod_dz;
    logic [DIV_W-1:0]  prod_cz;
    logic [3:0]        settle_w;

    assign accept    = start && (state == S_IDLE || state == S_HOLD);
    assign busy      = !(state == S_IDLE || state == S_HOLD);
    assign done      = (state == S_HOLD);
    assign div_start = busy && !launched;

    assign prod_dz = DIV_W'(DZ_MUL) * DIV_W'(r_rate);
    assign prod_cz = DIV_W'(CZ_MUL) * DIV_W'(r_rate);

    // Operand selection for the shared divider
    always_comb begin
        div_num = '0;
        div_den = DIV_W'(1);
        unique case (state)
            S_PREP: begin
                div_den = DIV_W'(r_per);
                if (r_prep >= r_per) div_num = DIV_W'(r_prep - r_per) << 1;
            end
            S_DZERO: begin
                div_den = DIV_W'(DZ_DIV);
                if (prod_dz > DIV_W'(DZ_SUB)) div_num = prod_dz - DIV_W'(DZ_SUB);
            end
            S_CZERO: begin
                div_den = DIV_W'(CZ_DIV);
                if (prod_cz > DIV_W'(CZ_SUB)) div_num = prod_cz - DIV_W'(CZ_SUB);
            end
            S_TRAIL: begin
                div_den = DIV_W'(TR_DIV);
                div_num = DIV_W'(TR_MUL) * DIV_W'(r_rate) + DIV_W'(TR_ADD);
            end
            S_IDLE, S_HOLD: ;
        endcase
    end

    lanetim_divider #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quot  (div_q)
    );

    lanetim_settle #(.RATE_W(RATE_W)) u_settle (
        .rate (rate_mbps),
        .code (settle_w)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE, S_HOLD: if (start)    state_nx = S_PREP;
            S_PREP:         if (div_done) state_nx = S_DZERO;
            S_DZERO:        if (div_done) state_nx = S_CZERO;
            S_CZERO:        if (div_done) state_nx = S_TRAIL;
            S_TRAIL:        if (div_done) state_nx = S_HOLD;
        endcase
    end

    // Output and operand registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_rate         <= '0;
            r_per          <= '0;
            r_prep         <= '0;
            launched       <= 1'b0;
            data_prep_err  <= 1'b0;
            clk_prep_err   <= 1'b0;
            data_prep_code <= '0;
            clk_prep_code  <= 1'b0;
            data_zero      <= '0;
            clk_zero       <= '0;
            trail_cnt      <= '0;
            settle_code    <= '0;
        end else begin
            if (accept) begin
                r_rate        <= rate_mbps;
                r_per         <= lp_period_ps;
                r_prep        <= data_prep_ps;
                data_prep_err <= (EW'(data_prep_ps) << 1) > EW'(lp_period_ps) * EW'(5);
                clk_prep_err  <= (EW'(clk_prep_ps) << 1) > EW'(lp_period_ps) * EW'(3);
                clk_prep_code <= clk_prep_ps > lp_period_ps;
                settle_code   <= settle_w;
            end
            if (div_start) launched <= 1'b1;
            if (div_done) begin
                launched <= 1'b0;
                case (state)
                    S_PREP:  data_prep_code <= (div_q > DIV_W'(3)) ? 2'd3 : div_q[1:0];
                    S_DZERO: data_zero <= (div_q == '0) ? 8'd1 :
                                          (div_q > DIV_W'(255)) ? 8'd255 : div_q[7:0];
                    S_CZERO: clk_zero  <= (div_q == '0) ? 8'd1 :
                                          (div_q > DIV_W'(255)) ? 8'd255 : div_q[7:0];
                    S_TRAIL: trail_cnt <= (div_q == '0) ? 4'd1 :
                                          (div_q > DIV_W'(TR_MAX)) ? 4'(TR_MAX) : div_q[3:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/lanetim_gen_chk.sv
module lanetim_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       data_prep_err,
    input logic       clk_prep_err,
    input logic [1:0] data_prep_code,
    input logic       clk_prep_code,
    input logic [7:0] data_zero,
    input logic [7:0] clk_zero,
    input logic [3:0] trail_cnt,
    input logic [3:0] settle_code
);
    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    assert_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_dzero_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (data_zero != 8'd0));

    assert_czero_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (clk_zero != 8'd0));

    assert_trail_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (trail_cnt >= 4'd1 && trail_cnt <= 4'd15));

    assert_settle_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (settle_code >= 4'd7 && settle_code <= 4'd13));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(data_prep_code) && $stable(clk_prep_code)
            && $stable(data_zero) && $stable(clk_zero) && $stable(trail_cnt)
            && $stable(settle_code) && $stable(data_prep_err) && $stable(clk_prep_err)));
endmodule

bind lanetim_gen lanetim_gen_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .busy           (busy),
    .done           (done),
    .data_prep_err  (data_prep_err),
    .clk_prep_err   (clk_prep_err),
    .data_prep_code (data_prep_code),
    .clk_prep_code  (clk_prep_code),
    .data_zero      (data_zero),
    .clk_zero       (clk_zero),
    .trail_cnt      (trail_cnt),
    .settle_code    (settle_code)
);

// File: tb/lanetim_gen_tb.sv
module lanetim_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] rate_mbps = '0;
    logic [19:0] lp_period_ps = '0;
    logic [19:0] data_prep_ps = '0;
    logic [19:0] clk_prep_ps = '0;
    logic        busy, done, data_prep_err, clk_prep_err, clk_prep_code;
    logic [1:0]  data_prep_code;
    logic [7:0]  data_zero, clk_zero;
    logic [3:0]  trail_cnt, settle_code;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lanetim_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rate_mbps(rate_mbps),
        .lp_period_ps(lp_period_ps), .data_prep_ps(data_prep_ps), .clk_prep_ps(clk_prep_ps),
        .busy(busy), .done(done), .data_prep_err(data_prep_err), .clk_prep_err(clk_prep_err),
        .data_prep_code(data_prep_code), .clk_prep_code(clk_prep_code),
        .data_zero(data_zero), .clk_zero(clk_zero), .trail_cnt(trail_cnt),
        .settle_code(settle_code)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint clampz(input longint v, input longint hi);
        if (v < 1) return 1;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic longint ref_dprep(input longint p, input longint t);
        longint q;
        if (p < t) return 0;
        q = (2 * (p - t)) / t;
        return (q > 3) ? 3 : q;
    endfunction

    function automatic longint ref_dzero(input longint r);
        longint n = 144 * r - 47500;
        if (n < 0) n = 0;
        return clampz(n / 10000, 255);
    endfunction

    function automatic longint ref_czero(input longint r);
        longint n = 34 * r - 2500;
        if (n < 0) n = 0;
        return clampz(n / 1000, 255);
    endfunction

    function automatic longint ref_trail(input longint r);
        return clampz((103 * r + 10000) / 10000, 15);
    endfunction

    function automatic longint ref_settle(input longint r);
        if (r < 80)  return 13;
        if (r < 90)  return 12;
        if (r < 125) return 11;
        if (r < 150) return 10;
        if (r < 225) return 9;
        if (r < 500) return 8;
        return 7;
    endfunction

    task automatic compare_all(input longint r, input longint t, input longint p, input longint c);
        check("R2", "data_prep_code", data_prep_code, ref_dprep(p, t));
        check("R3", "data_prep_err", data_prep_err, (2 * p > 5 * t) ? 1 : 0);
        check("R4", "clk_prep_code", clk_prep_code, (c > t) ? 1 : 0);
        check("R4", "clk_prep_err", clk_prep_err, (2 * c > 3 * t) ? 1 : 0);
        check("R5", "data_zero", data_zero, ref_dzero(r));
        check("R6", "clk_zero", clk_zero, ref_czero(r));
        check("R7", "trail_cnt", trail_cnt, ref_trail(r));
        check("R8", "settle_code", settle_code, ref_settle(r));
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R1", "done reached", done, 1);
    endtask

    task automatic launch(input longint r, input longint t, input longint p, input longint c);
        @(negedge clk);
        rate_mbps = 11'(r); lp_period_ps = 20'(t); data_prep_ps = 20'(p); clk_prep_ps = 20'(c);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input longint r, input longint t, input longint p, input longint c);
        launch(r, t, p, c);
        wait_done();
        compare_all(r, t, p, c);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "busy after reset", busy, 0);
        check("R9", "done after reset", done, 0);
        check("R9", "data_zero after reset", data_zero, 0);
        check("R9", "settle_code after reset", settle_code, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: accept from idle
        launch(1000, 50000, 60000, 60000);
        check("R1", "busy after start", busy, 1);
        check("R1", "done after start", done, 0);
        wait_done();
        compare_all(1000, 50000, 60000, 60000);

        // Directed corners: low rates where zero formulas go negative (R5, R6)
        run(0, 10000, 9999, 10000);
        run(1, 10000, 10000, 10001);
        run(73, 10000, 15000, 15000);
        run(74, 10000, 15001, 15001);
        run(330, 10000, 25000, 20000);
        run(331, 10000, 25001, 14999);
        // Settle ladder boundaries (R8) and trail clamp (R7)
        foreach (SETTLE_EDGES[i]) begin
            run(SETTLE_EDGES[i] - 1, 8000, 20000, 12000);
            run(SETTLE_EDGES[i], 8000, 20000, 12001);
        end
        run(1359, 7, 17, 11);
        run(1360, 7, 18, 10);
        run(2047, 1, 3, 2);

        // R1: start during busy is ignored
        launch(500, 40000, 90000, 50000);
        repeat (7) @(negedge clk);
        rate_mbps = 11'd60; lp_period_ps = 20'd100; data_prep_ps = 20'd5; clk_prep_ps = 20'd500;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        compare_all(500, 40000, 90000, 50000);

        // R9: outputs hold after done while inputs move
        rate_mbps = 11'd3; lp_period_ps = 20'd9; data_prep_ps = 20'd99; clk_prep_ps = 20'd1;
        repeat (12) @(negedge clk);
        check("R9", "done held", done, 1);
        compare_all(500, 40000, 90000, 50000);

        // Constrained random
        for (int k = 0; k < 300; k++) begin
            longint r, t, p, c;
            r = $urandom % 2048;
            t = 1 + ($urandom % 200000);
            p = $urandom % (3 * t + 2);
            c = $urandom % (2 * t + 2);
            if (p > 1048575) p = 1048575;
            if (c > 1048575) c = 1048575;
            run(r, t, p, c);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam longint SETTLE_EDGES [7] = '{80, 90, 125, 150, 225, 500, 1000};
endmodule